// File: doc/BRIEF.md
# Multi-Mode Address Generation ALU

This block computes memory addresses for a datapath that walks buffers in several patterns. It holds four register triplets. Each triplet has an address, an offset (step) and a modifier. The modifier of a triplet sets the kind of arithmetic used on its address: plain linear stepping, circular (modulo) buffers of any length, power-of-two blocks that wrap inside themselves, or reverse-carry stepping for the bit-reversed order that FFT stages need.

Each accepted operation names one triplet and one step type: plus one, minus one, plus the offset register, or no change. In the same cycle the block forms the candidate new address with three adders that run side by side and selects one result by the modifier. It writes that result back to the address register and registers an effective address. This address is the old value for post-modify and the new value for pre-modify. A separate load port writes any field of any triplet, so loading and address arithmetic can happen in the same cycle.

Top module: `addr_gen_alu`

## Requirements
- R1: On reset all address and offset registers become 0, every modifier becomes all ones (linear), and `ea_valid` and `ea_out` are 0.
- R2: When `wr_en` is high, `wr_data` is written into the field of triplet `wr_idx` that `wr_field` selects (0 address, 1 offset, 2 modifier). The code 3 writes nothing.
- R3: `ea_valid` and `ea_out` update one clock after `op_valid`. An address updated by one operation is the input of an operation in the very next cycle.
- R4: With `op_pre` low, `ea_out` is the address before the update (post-modify). With `op_pre` high, it is the updated address (pre-modify).
- R5: `op_step` codes are 0 plus one, 1 minus one, 2 plus the offset register (two's complement), and 3 no update. With modifier 0xFFFFFF the update is a plain 24-bit add that wraps around.
- R6: A modifier of 1 to 0x7FFF selects a circular buffer of length M+1. Its base is the address with its low ceil(log2(M+1)) bits cleared. A sum past base+M is reduced by M+1, and a sum below the base is raised by M+1. Steps are no larger than M+1.
- R7: A modifier with bits 23..16 zero and bit 15 set selects block wrap with block size (bits 14..0)+1, a power of two. The update changes only the address bits below the block size and keeps the upper bits.
- R8: A modifier of 0 selects reverse-carry addition, with the carry moving from bit 23 toward bit 0. With an offset of half of a 2^k buffer, successive addresses follow the k-bit bit-reversed order.
- R9: Any modifier not covered by R5 to R8 behaves as linear.
- R10: An operation changes only the address register of the selected triplet. Step code 3 leaves it unchanged.
- R11: When a load and an update fall in the same cycle, the operation uses the register values from before that cycle. A load into the address register being updated wins over the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Starts an address operation this cycle |
| op_idx | input | 2 | Triplet used by the operation |
| op_step | input | 2 | Step type: inc, dec, add offset, none |
| op_pre | input | 1 | 1 = pre-modify, 0 = post-modify |
| wr_en | input | 1 | Load strobe |
| wr_field | input | 2 | Field to load: address, offset, modifier, none |
| wr_idx | input | 2 | Triplet to load |
| wr_data | input | 24 | Load value |
| ea_valid | output | 1 | Effective address valid |
| ea_out | output | 24 | Effective address |

## Verification
A register load and an address update can hit the same triplet in the same clock. The bench provokes this with one cycle that loads the address register while stepping it, and another that loads the offset register while adding that offset. It judges the effective address of that cycle against the old values, then reads back the stored address and repeats the offset step to see which write survived and that the new offset is now in use.

// File: rtl/agu_pkg.sv
package agu_pkg;

    // Width of the length field inside a modifier word; the bit just above it
    // marks block-wrap mode.
    localparam int MFW = 15;

    typedef enum logic [1:0] {
        STEP_INC  = 2'b00,
        STEP_DEC  = 2'b01,
        STEP_OFS  = 2'b10,
        STEP_NONE = 2'b11
    } step_e;

    typedef enum logic [1:0] {
        FLD_ADDR = 2'b00,
        FLD_OFS  = 2'b01,
        FLD_MOD  = 2'b10,
        FLD_NONE = 2'b11
    } field_e;

    typedef enum logic [1:0] {
        AM_LINEAR = 2'b00,
        AM_MODULO = 2'b01,
        AM_MWRAP  = 2'b10,
        AM_REVC   = 2'b11
    } amode_e;

    typedef struct packed {
        amode_e           mode;
        logic [MFW-1:0]   span;   // M: buffer length minus one
    } decode_t;

    // Arithmetic kind from summary flags of a modifier word.
    function automatic amode_e classify(input logic all_one,
                                        input logic all_zero,
                                        input logic hi_zero,
                                        input logic wrap_bit);
        amode_e m;
        if (all_one)       m = AM_LINEAR;
        else if (all_zero) m = AM_REVC;
        else if (hi_zero)  m = wrap_bit ? AM_MWRAP : AM_MODULO;
        else               m = AM_LINEAR;
        return m;
    endfunction

endpackage

// File: rtl/agu_regfile.sv
module agu_regfile
    import agu_pkg::*;
#(
    parameter int AW    = 24,
    parameter int NSETS = 4,
    localparam int IDXW = $clog2(NSETS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  field_e          wr_fld,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [AW-1:0]   wr_data,
    input  logic            upd_en,
    input  logic [IDXW-1:0] upd_idx,
    input  logic [AW-1:0]   upd_addr,
    input  logic [IDXW-1:0] rd_idx,
    output logic [AW-1:0]   rd_addr,
    output logic [AW-1:0]   rd_ofs,
    output logic [AW-1:0]   rd_mod
);

    logic [AW-1:0] addr_q [NSETS];
    logic [AW-1:0] ofs_q  [NSETS];
    logic [AW-1:0] mod_q  [NSETS];

    logic [NSETS-1:0] ld_addr, ld_ofs, ld_mod, step_hit;

    // Per-triplet strobes
    for (genvar g = 0; g < NSETS; g++) begin : g_sel
        logic idx_match;
        assign idx_match   = wr_en && (wr_idx == IDXW'(g));
        assign ld_addr[g]  = idx_match && (wr_fld == FLD_ADDR);
        assign ld_ofs[g]   = idx_match && (wr_fld == FLD_OFS);
        assign ld_mod[g]   = idx_match && (wr_fld == FLD_MOD);
        assign step_hit[g] = upd_en && (upd_idx == IDXW'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSETS; i++) begin
                addr_q[i] <= '0;
                ofs_q[i]  <= '0;
                mod_q[i]  <= '1;
            end
        end else begin
            for (int i = 0; i < NSETS; i++) begin
                // R11: a load beats the arithmetic write-back
                if (ld_addr[i])       addr_q[i] <= wr_data;
                else if (step_hit[i]) addr_q[i] <= upd_addr;
                if (ld_ofs[i])        ofs_q[i]  <= wr_data;
                if (ld_mod[i])        mod_q[i]  <= wr_data;
            end
        end
    end

    assign rd_addr = addr_q[rd_idx];
    assign rd_ofs  = ofs_q[rd_idx];
    assign rd_mod  = mod_q[rd_idx];

endmodule

// File: rtl/agu_lin_mod_path.sv
module agu_lin_mod_path
    import agu_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic [AW-1:0]  cur,
    input  logic [AW-1:0]  step,
    input  logic [MFW-1:0] span,
    output logic [AW-1:0]  lin_sum,
    output logic [AW-1:0]  mod_sum,
    output logic [AW-1:0]  wrap_sum
);

    localparam int EW = AW + 2;

    logic [AW-1:0] span_w, ring_mask, base, top;
    logic signed [EW-1:0] sum_x, base_x, top_x, len_x, corr_x, fix_x;

    // Fill every bit below the highest set bit of M: 2^ceil(log2(M+1)) - 1
    function automatic logic [AW-1:0] smear(input logic [AW-1:0] v);
        logic [AW-1:0] r;
        r = v;
        for (int i = AW - 2; i >= 0; i--) r[i] = r[i] | r[i+1];
        return r;
    endfunction

    always_comb begin
        span_w    = AW'(span);
        ring_mask = smear(span_w);
        base      = cur & ~ring_mask;
        top       = base + span_w;

        // Offset adder, extended by two bits so the bound tests see the sign
        sum_x   = $signed({2'b00, cur}) + $signed({{2{step[AW-1]}}, step});
        lin_sum = sum_x[AW-1:0];

        // Modulo correction adder
        base_x = $signed({2'b00, base});
        top_x  = $signed({2'b00, top});
        len_x  = $signed({2'b00, span_w}) + EW'(1);
        if (sum_x > top_x)       corr_x = -len_x;
        else if (sum_x < base_x) corr_x = len_x;
        else                     corr_x = '0;
        fix_x   = sum_x + corr_x;
        mod_sum = fix_x[AW-1:0];

        // Block wrap: low bits from the sum, upper bits kept
        wrap_sum = (cur & ~span_w) | (lin_sum & span_w);
    end

endmodule

// File: rtl/agu_revc_adder.sv
module agu_revc_adder #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    output logic [AW-1:0] sum
);

    // Carry runs from the top bit downward; the carry out of bit 0 is lost.
    always_comb begin
        logic cy;
        cy = 1'b0;
        for (int i = AW - 1; i >= 0; i--) begin
            sum[i] = a[i] ^ b[i] ^ cy;
            cy     = (a[i] & b[i]) | (a[i] & cy) | (b[i] & cy);
        end
    end

endmodule

// File: rtl/addr_gen_alu.sv
module addr_gen_alu
    import agu_pkg::*;
#(
    parameter int AW    = 24,
    parameter int NSETS = 4,
    localparam int IDXW = $clog2(NSETS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [IDXW-1:0] op_idx,
    input  logic [1:0]      op_step,
    input  logic            op_pre,
    input  logic            wr_en,
    input  logic [1:0]      wr_field,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [AW-1:0]   wr_data,
    output logic            ea_valid,
    output logic [AW-1:0]   ea_out
);

    typedef struct packed {
        logic [AW-1:0] lin;
        logic [AW-1:0] modc;
        logic [AW-1:0] wrap;
        logic [AW-1:0] revc;
    } cand_t;

    step_e         step_kind;
    decode_t       dec;
    amode_e        mode_sel;
    logic [MFW-1:0] mfield;
    cand_t         cand;
    logic [AW-1:0] cur_addr, cur_ofs, cur_mod;
    logic [AW-1:0] step_val, next_addr;
    logic          upd_en;

    assign step_kind = step_e'(op_step);
    assign upd_en    = op_valid && (step_kind != STEP_NONE);

    agu_regfile #(.AW(AW), .NSETS(NSETS)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_fld   (field_e'(wr_field)),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .upd_en   (upd_en),
        .upd_idx  (op_idx),
        .upd_addr (next_addr),
        .rd_idx   (op_idx),
        .rd_addr  (cur_addr),
        .rd_ofs   (cur_ofs),
        .rd_mod   (cur_mod)
    );

    // Modifier decode
    always_comb begin
        dec.mode = classify(&cur_mod, cur_mod == '0,
                            cur_mod[AW-1:MFW+1] == '0, cur_mod[MFW]);
        dec.span = cur_mod[MFW-1:0];
    end
    assign mode_sel = dec.mode;
    assign mfield   = dec.span;

    // Step operand
    always_comb begin
        unique case (step_kind)
            STEP_INC: step_val = AW'(1);
            STEP_DEC: step_val = '1;
            STEP_OFS: step_val = cur_ofs;
            default:  step_val = '0;
        endcase
    end

    agu_lin_mod_path #(.AW(AW)) u_lm (
        .cur      (cur_addr),
        .step     (step_val),
        .span     (mfield),
        .lin_sum  (cand.lin),
        .mod_sum  (cand.modc),
        .wrap_sum (cand.wrap)
    );

    agu_revc_adder #(.AW(AW)) u_rc (
        .a   (cur_addr),
        .b   (step_val),
        .sum (cand.revc)
    );

    // Result selection
    always_comb begin
        unique case (mode_sel)
            AM_MODULO: next_addr = cand.modc;
            AM_MWRAP:  next_addr = cand.wrap;
            AM_REVC:   next_addr = cand.revc;
            default:   next_addr = cand.lin;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ea_valid <= 1'b0;
            ea_out   <= '0;
        end else begin
            ea_valid <= op_valid;
            if (op_valid) ea_out <= op_pre ? next_addr : cur_addr;
        end
    end

endmodule

// File: rtl/agu_chk.sv
module agu_chk
    import agu_pkg::*;
#(
    parameter int AW = 24
) (
    input logic           clk,
    input logic           rst,
    input logic           op_valid,
    input logic           op_pre,
    input logic           ea_valid,
    input logic [AW-1:0]  ea_out,
    input logic [AW-1:0]  cur_addr,
    input logic [AW-1:0]  next_addr,
    input amode_e         mode_sel,
    input logic [MFW-1:0] mfield
);

    logic [AW-1:0] m_w, m_fill, lo_b, hi_b;
    logic cur_in, nxt_in;

    always_comb begin
        m_w    = AW'(mfield);
        m_fill = m_w;
        for (int i = AW - 2; i >= 0; i--) m_fill[i] = m_fill[i] | m_fill[i+1];
        lo_b   = cur_addr & ~m_fill;
        hi_b   = lo_b + m_w;
        cur_in = (cur_addr >= lo_b) && (cur_addr <= hi_b);
        nxt_in = (next_addr >= lo_b) && (next_addr <= hi_b);
    end

    p_strobe_on_r3: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> ea_valid);

    p_strobe_off_r3: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !ea_valid);

    p_post_ea_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_pre) |=> (ea_out == $past(cur_addr)));

    p_pre_ea_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_pre) |=> (ea_out == $past(next_addr)));

    p_ring_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode_sel == AM_MODULO && cur_in) |-> nxt_in);

    p_block_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode_sel == AM_MWRAP) |-> ((next_addr & ~m_w) == (cur_addr & ~m_w)));

endmodule

bind addr_gen_alu agu_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_pre    (op_pre),
    .ea_valid  (ea_valid),
    .ea_out    (ea_out),
    .cur_addr  (cur_addr),
    .next_addr (next_addr),
    .mode_sel  (mode_sel),
    .mfield    (mfield)
);

// File: tb/sim_addr_gen_alu.sv
`timescale 1ns/1ps
module sim_addr_gen_alu;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_idx;
    logic [1:0]  op_step;
    logic        op_pre;
    logic        wr_en;
    logic [1:0]  wr_field;
    logic [1:0]  wr_idx;
    logic [23:0] wr_data;
    logic        ea_valid;
    logic [23:0] ea_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    addr_gen_alu u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_idx(op_idx),
        .op_step(op_step), .op_pre(op_pre), .wr_en(wr_en), .wr_field(wr_field),
        .wr_idx(wr_idx), .wr_data(wr_data), .ea_valid(ea_valid), .ea_out(ea_out)
    );

    localparam logic [1:0] S_INC = 2'd0, S_DEC = 2'd1, S_OFS = 2'd2, S_NONE = 2'd3;
    localparam logic [1:0] F_ADDR = 2'd0, F_OFS = 2'd1, F_MOD = 2'd2, F_NONE = 2'd3;

    // {req, idx, step, pre, expected effective address}
    localparam int NV = 16;
    localparam logic [36:0] VECS [NV] = '{
        {8'd5,  2'd0, S_INC,  1'b0, 24'h000010},
        {8'd5,  2'd0, S_OFS,  1'b0, 24'h000011},
        {8'd4,  2'd0, S_DEC,  1'b1, 24'h000015},
        {8'd10, 2'd0, S_NONE, 1'b0, 24'h000015},
        {8'd6,  2'd1, S_OFS,  1'b0, 24'h000025},
        {8'd6,  2'd1, S_OFS,  1'b0, 24'h000028},
        {8'd6,  2'd1, S_DEC,  1'b1, 24'h000020},
        {8'd6,  2'd1, S_DEC,  1'b1, 24'h000029},
        {8'd6,  2'd1, S_INC,  1'b1, 24'h000020},
        {8'd7,  2'd3, S_OFS,  1'b0, 24'h000106},
        {8'd7,  2'd3, S_DEC,  1'b1, 24'h000100},
        {8'd7,  2'd3, S_DEC,  1'b1, 24'h000107},
        {8'd7,  2'd3, S_INC,  1'b0, 24'h000107},
        {8'd7,  2'd3, S_NONE, 1'b0, 24'h000100},
        {8'd10, 2'd0, S_NONE, 1'b0, 24'h000015},
        {8'd10, 2'd1, S_NONE, 1'b0, 24'h000020}
    };

    task automatic chk(input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] fld, input logic [1:0] idx, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_field = fld; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One operation, optionally with a load in the same cycle; returns ea_out
    task automatic run_op(input logic [1:0] idx, input logic [1:0] st, input logic pre,
                          input logic do_wr, input logic [1:0] fld, input logic [23:0] d,
                          output logic [23:0] ea);
        @(negedge clk);
        op_valid = 1'b1; op_idx = idx; op_step = st; op_pre = pre;
        wr_en = do_wr; wr_field = fld; wr_idx = idx; wr_data = d;
        @(negedge clk);
        op_valid = 1'b0; wr_en = 1'b0;
        ea = ea_out;
        chk("R3", "ea_valid after op", {23'd0, ea_valid}, 24'd1);
    endtask

    function automatic logic [23:0] bitrev4(input int i);
        logic [3:0] v;
        v = 4'(i);
        return {20'd0, v[0], v[1], v[2], v[3]};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R3 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [23:0] ea;
        rst = 1'b1; op_valid = 1'b0; op_idx = '0; op_step = '0; op_pre = 1'b0;
        wr_en = 1'b0; wr_field = '0; wr_idx = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1", "ea_valid at reset", {23'd0, ea_valid}, 24'd0);
        chk("R1", "ea_out at reset", ea_out, 24'd0);
        run_op(2'd2, S_NONE, 1'b0, 1'b0, F_NONE, 24'd0, ea);
        chk("R1", "address cleared", ea, 24'd0);
        run_op(2'd2, S_INC, 1'b1, 1'b0, F_NONE, 24'd0, ea);
        chk("R1", "modifier linear", ea, 24'd1);
        run_op(2'd3, S_OFS, 1'b1, 1'b0, F_NONE, 24'd0, ea);
        chk("R1", "offset cleared", ea, 24'd0);
        @(negedge clk);
        chk("R3", "ea_valid idle", {23'd0, ea_valid}, 24'd0);

        // R2: setup loads
        load(F_ADDR, 2'd0, 24'h000010); load(F_OFS, 2'd0, 24'h000005);
        load(F_MOD,  2'd1, 24'h000009); load(F_ADDR, 2'd1, 24'h000025);
        load(F_OFS,  2'd1, 24'h000003);
        load(F_MOD,  2'd3, 24'h008007); load(F_ADDR, 2'd3, 24'h000106);
        load(F_OFS,  2'd3, 24'h000003);

        for (int k = 0; k < NV; k++) begin
            logic [36:0] v;
            v = VECS[k];
            run_op(v[28:27], v[26:25], v[24], 1'b0, F_NONE, 24'd0, ea);
            chk($sformatf("R%0d", v[36:29]), $sformatf("vector %0d", k), ea, v[23:0]);
        end

        // R8: reverse-carry with half-buffer offset gives bit-reversed order
        load(F_MOD, 2'd2, 24'h000000); load(F_ADDR, 2'd2, 24'h000000);
        load(F_OFS, 2'd2, 24'h000008);
        for (int k = 0; k < 16; k++) begin
            run_op(2'd2, S_OFS, 1'b0, 1'b0, F_NONE, 24'd0, ea);
            chk("R8", $sformatf("bit-reverse step %0d", k), ea, bitrev4(k));
        end
        run_op(2'd2, S_NONE, 1'b0, 1'b0, F_NONE, 24'd0, ea);
        chk("R8", "reverse wraps to base", ea, 24'd0);

        // R5: linear wrap at the 24-bit edge
        load(F_ADDR, 2'd0, 24'hFFFFFF);
        run_op(2'd0, S_INC, 1'b1, 1'b0, F_NONE, 24'd0, ea);
        chk("R5", "inc wraps to zero", ea, 24'h000000);
        run_op(2'd0, S_DEC, 1'b1, 1'b0, F_NONE, 24'd0, ea);
        chk("R5", "dec wraps to top", ea, 24'hFFFFFF);

        // R9: reserved modifier acts as linear
        load(F_MOD, 2'd0, 24'h018003); load(F_ADDR, 2'd0, 24'h000107);
        run_op(2'd0, S_INC, 1'b1, 1'b0, F_NONE, 24'd0, ea);
        chk("R9", "reserved modifier linear", ea, 24'h000108);

        // R11: load and update in the same cycle
        load(F_MOD, 2'd0, 24'hFFFFFF); load(F_ADDR, 2'd0, 24'h000200);
        load(F_OFS, 2'd0, 24'h000010);
        run_op(2'd0, S_OFS, 1'b0, 1'b1, F_ADDR, 24'h000500, ea);
        chk("R11", "collision ea uses old address", ea, 24'h000200);
        run_op(2'd0, S_NONE, 1'b0, 1'b0, F_NONE, 24'd0, ea);
        chk("R11", "load wins over update", ea, 24'h000500);
        run_op(2'd0, S_OFS, 1'b1, 1'b1, F_OFS, 24'h000040, ea);
        chk("R11", "collision uses old offset", ea, 24'h000510);
        run_op(2'd0, S_OFS, 1'b1, 1'b0, F_NONE, 24'd0, ea);
        chk("R11", "new offset in use", ea, 24'h000550);

        // R2: field code 3 writes nothing
        load(F_NONE, 2'd0, 24'hABCDEF);
        run_op(2'd0, S_NONE, 1'b0, 1'b0, F_NONE, 24'd0, ea);
        chk("R2", "no-field load keeps address", ea, 24'h000550);
        run_op(2'd0, S_OFS, 1'b1, 1'b0, F_NONE, 24'd0, ea);
        chk("R2", "no-field load keeps offset", ea, 24'h000590);

        // R3: back-to-back operations on one triplet
        @(negedge clk);
        op_valid = 1'b1; op_idx = 2'd0; op_step = S_INC; op_pre = 1'b0;
        @(negedge clk);
        chk("R3", "first of burst", ea_out, 24'h000590);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R3", "second of burst sees update", ea_out, 24'h000591);
        chk("R3", "valid in burst", {23'd0, ea_valid}, 24'd1);
        @(negedge clk);
        chk("R3", "valid drops after burst", {23'd0, ea_valid}, 24'd0);
        run_op(2'd0, S_NONE, 1'b0, 1'b0, F_NONE, 24'd0, ea);
        chk("R10", "hold after burst", ea, 24'h000592);
        run_op(2'd3, S_NONE, 1'b0, 1'b0, F_NONE, 24'd0, ea);
        chk("R10", "other triplet untouched", ea, 24'h000100);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule